// File: doc/BRIEF.md
# Power-Fail Bus Guard

This block sits between a system bus and a byte-wide battery-backed memory and decides, from the state of the supply, whether the memory may be selected, written or allowed to drive its data pins. Three comparator flags arrive asynchronously: supply within tolerance, supply above the battery switchover level, and battery voltage low. The block resynchronises them, then produces a gated chip select, a gated write strobe, an output-drive qualifier and a power-source select. All outputs are registered.

When the supply leaves tolerance, the memory is deselected and write-protected at once. Any write in progress is cut short. When the supply comes back, protection is held for a programmable number of clock cycles before bus traffic is let through again.

Each time the supply rises past the switchover level, the battery-low flag is sampled. If the battery is weak, a sticky battery-not-OK flag is set. That flag swallows the next complete write cycle and then clears itself. Software can read the flag on a status output to learn that the battery needs attention.

Top module: `pwrfail_bus_guard`

## Requirements
- R1: While `rst` is high and on the first edge after it, the outputs take these values: `mem_ce_n`=1, `mem_we_n`=1, `mem_drv_en`=0, `pwr_sel_batt`=1 and `batt_bad`=0.
- R2: `SYNC_STAGES`+1 rising edges after `vcc_ok` falls, `mem_ce_n` and `mem_we_n` are 1 and `mem_drv_en` is 0. A write in progress is cut off at that edge. While the supply stays low, bus inputs have no effect.
- R3: `pwr_sel_batt` equals the inverse of `vcc_above_sw`, delayed by `SYNC_STAGES`+1 rising edges (1 = battery).
- R4: After `vcc_ok` rises and stays high, bus requests reach the memory outputs from the (`SYNC_STAGES`+`TREC_CYCLES`+1)th rising edge onward, and not before.
- R5: A low pulse on `vcc_ok` during the recovery count restarts the count from the next rise.
- R6: On a 0-to-1 change of the synchronised `vcc_above_sw`, `batt_bad` is set if the synchronised `batt_low` is 1 at that moment. The flag becomes visible `SYNC_STAGES`+1 edges after the inputs change.
- R7: `batt_low` rising while `vcc_above_sw` stays high leaves `batt_bad` at 0.
- R8: While `batt_bad`=1, the first write cycle under operational conditions never drives `mem_we_n` low, but `mem_ce_n` still follows the bus. `batt_bad` clears on the edge after that write cycle ends. A write cycle ends when `bus_ce_n` or `bus_we_n` goes high.
- R9: After `batt_bad` clears, the next write cycle drives `mem_we_n` low one edge after the request.
- R10: In operation the outputs, one edge after the bus inputs, follow these rules. `mem_ce_n` = `bus_ce_n`. `mem_we_n` is 0 only when `bus_ce_n`=0 and `bus_we_n`=0. `mem_drv_en` is 1 only when `bus_ce_n`=0, `bus_oe_n`=0 and `bus_we_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_ok | input | 1 | Supply within tolerance (asynchronous) |
| vcc_above_sw | input | 1 | Supply above battery switchover level (asynchronous) |
| batt_low | input | 1 | Battery voltage low (asynchronous) |
| bus_ce_n | input | 1 | Bus chip select, active low |
| bus_we_n | input | 1 | Bus write strobe, active low |
| bus_oe_n | input | 1 | Bus output enable, active low |
| mem_ce_n | output | 1 | Gated chip select to memory, active low |
| mem_we_n | output | 1 | Gated write strobe to memory, active low |
| mem_drv_en | output | 1 | Memory data pins may drive when 1 |
| pwr_sel_batt | output | 1 | 1 selects battery, 0 selects main supply |
| batt_bad | output | 1 | Battery-not-OK status flag |

## Verification
The bench builds the guard with `SYNC_STAGES`=2 and `TREC_CYCLES`=5, so that the full recovery window of eight edges is short. With that window, the exact edge on which protection lifts can be probed from both sides. A supply glitch can also be placed inside the window to show that the count restarts. The default recovery length of 1000 cycles would only stretch the run without reaching any new state. Two stages keep the stated latencies of deselect, source select and flag setting easy to count at the ports.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  typedef enum logic [1:0] {
    RC_DOWN  = 2'd0,
    RC_COUNT = 2'd1,
    RC_READY = 2'd2
  } rec_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
  } bus_req_t;

  function automatic logic is_write(input bus_req_t r);
    return !r.ce_n && !r.we_n;
  endfunction

  function automatic logic is_read(input bus_req_t r);
    return !r.ce_n && r.we_n && !r.oe_n;
  endfunction

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pfg_recovery.sv
module pfg_recovery
  import pfg_pkg::*;
#(
  parameter int TREC_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic s_ok,
  output logic op_en
);
  localparam int CW = $clog2(TREC_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TREC_CYCLES - 1);

  rec_state_e    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RC_DOWN;
      cnt_q   <= '0;
    end else if (!s_ok) begin
      state_q <= RC_DOWN;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        RC_DOWN: begin
          if (TREC_CYCLES <= 1) begin
            state_q <= RC_READY;
          end else begin
            state_q <= RC_COUNT;
            cnt_q   <= CW'(1);
          end
        end
        RC_COUNT: begin
          if (cnt_q >= LAST) state_q <= RC_READY;
          else               cnt_q   <= cnt_q + CW'(1);
        end
        RC_READY: state_q <= RC_READY;
        default:  state_q <= RC_DOWN;
      endcase
    end
  end

  assign op_en = (state_q == RC_READY) && s_ok;

  // R4: the ready state is only ever held or entered with the supply good
  p_ready_after_ok_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == RC_READY) |-> $past(s_ok));

  // R5: a supply drop restarts the recovery window
  p_drop_restarts_r5: assert property (@(posedge clk) disable iff (rst)
    !s_ok |=> (state_q == RC_DOWN) && (cnt_q == '0));
endmodule

// File: rtl/pfg_battflag.sv
module pfg_battflag (
  input  logic clk,
  input  logic rst,
  input  logic s_above,
  input  logic s_blow,
  input  logic op_en,
  input  logic wr_req,
  output logic flag
);
  logic above_q;
  logic blocking_q;
  logic flag_q;
  logic power_up;
  logic wr_live;

  assign power_up = s_above && !above_q;
  assign wr_live  = op_en && wr_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      above_q    <= 1'b0;
      flag_q     <= 1'b0;
      blocking_q <= 1'b0;
    end else begin
      above_q <= s_above;
      if (power_up && s_blow) begin
        flag_q     <= 1'b1;
        blocking_q <= 1'b0;
      end else if (flag_q) begin
        if (wr_live) begin
          blocking_q <= 1'b1;
        end else if (blocking_q) begin
          flag_q     <= 1'b0;
          blocking_q <= 1'b0;
        end
      end
    end
  end

  assign flag = flag_q;

  // R8: the flag only drops after a write cycle has been swallowed
  p_clear_after_block_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(blocking_q));

  // R6: the flag is only raised with a weak battery observed
  p_set_needs_low_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(s_blow) && $past(s_above));
endmodule

// File: rtl/pfg_gate.sv
module pfg_gate
  import pfg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic op_en,
  input  logic flag,
  input  logic bus_ce_n,
  input  logic bus_we_n,
  input  logic bus_oe_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic mem_drv_en
);
  bus_req_t req;

  assign req = '{ce_n: bus_ce_n, we_n: bus_we_n, oe_n: bus_oe_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_drv_en <= 1'b0;
    end else begin
      mem_ce_n   <= !(op_en && !req.ce_n);
      mem_we_n   <= !(op_en && is_write(req) && !flag);
      mem_drv_en <= op_en && is_read(req);
    end
  end

  // R2: loss of operation deselects everything on the next edge
  p_deselect_r2: assert property (@(posedge clk) disable iff (rst)
    !op_en |=> mem_ce_n && mem_we_n && !mem_drv_en);

  // R8: a raised battery flag never lets a strobe through
  p_flag_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    flag |=> mem_we_n);

  // R10: a write strobe only inside a chip select
  p_we_inside_ce_r10: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);

  // R10: the data pins never drive during a write strobe
  p_no_drive_in_write_r10: assert property (@(posedge clk) disable iff (rst)
    mem_drv_en |-> mem_we_n && !mem_ce_n);
endmodule

// File: rtl/pwrfail_bus_guard.sv
module pwrfail_bus_guard
  import pfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TREC_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic vcc_ok,
  input  logic vcc_above_sw,
  input  logic batt_low,
  input  logic bus_ce_n,
  input  logic bus_we_n,
  input  logic bus_oe_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic mem_drv_en,
  output logic pwr_sel_batt,
  output logic batt_bad
);
  localparam int NFLAGS = 3;

  logic [NFLAGS-1:0] raw_flags;
  logic [NFLAGS-1:0] syn_flags;
  logic s_ok, s_above, s_blow;
  logic op_en;
  logic flag;
  logic wr_req;
  logic sel_q;
  bus_req_t req;

  assign raw_flags = {batt_low, vcc_above_sw, vcc_ok};

  pfg_sync #(.WIDTH(NFLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_flags),
    .q   (syn_flags)
  );

  assign s_ok    = syn_flags[0];
  assign s_above = syn_flags[1];
  assign s_blow  = syn_flags[2];

  pfg_recovery #(.TREC_CYCLES(TREC_CYCLES)) u_rec (
    .clk   (clk),
    .rst   (rst),
    .s_ok  (s_ok),
    .op_en (op_en)
  );

  assign req    = '{ce_n: bus_ce_n, we_n: bus_we_n, oe_n: bus_oe_n};
  assign wr_req = is_write(req);

  pfg_battflag u_flag (
    .clk     (clk),
    .rst     (rst),
    .s_above (s_above),
    .s_blow  (s_blow),
    .op_en   (op_en),
    .wr_req  (wr_req),
    .flag    (flag)
  );

  pfg_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .op_en      (op_en),
    .flag       (flag),
    .bus_ce_n   (bus_ce_n),
    .bus_we_n   (bus_we_n),
    .bus_oe_n   (bus_oe_n),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_drv_en (mem_drv_en)
  );

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b1;
    else     sel_q <= !s_above;
  end

  assign pwr_sel_batt = sel_q;
  assign batt_bad     = flag;

  // R3: below the switchover level the battery is chosen on the next edge
  p_batt_sel_r3: assert property (@(posedge clk) disable iff (rst)
    !s_above |=> pwr_sel_batt);

  // R3: above it the main supply is chosen on the next edge
  p_main_sel_r3: assert property (@(posedge clk) disable iff (rst)
    s_above |=> !pwr_sel_batt);
endmodule

// File: tb/sim_pwrfail_bus_guard.sv
module sim_pwrfail_bus_guard;
  localparam int SYNC = 2;
  localparam int TREC = 5;
  localparam int LAT  = SYNC + TREC + 1;

  logic clk = 1'b0;
  logic rst;
  logic vcc_ok, vcc_above_sw, batt_low;
  logic bus_ce_n, bus_we_n, bus_oe_n;
  logic mem_ce_n, mem_we_n, mem_drv_en, pwr_sel_batt, batt_bad;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pwrfail_bus_guard #(.SYNC_STAGES(SYNC), .TREC_CYCLES(TREC)) u0 (
    .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .vcc_above_sw(vcc_above_sw),
    .batt_low(batt_low), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
    .bus_oe_n(bus_oe_n), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_drv_en(mem_drv_en), .pwr_sel_batt(pwr_sel_batt), .batt_bad(batt_bad)
  );

  // {ce_n, we_n, oe_n, exp mem_ce_n, exp mem_we_n, exp mem_drv_en}
  localparam logic [5:0] VEC [8] = '{
    6'b000_000, 6'b001_000, 6'b010_011, 6'b011_010,
    6'b100_110, 6'b101_110, 6'b110_110, 6'b111_110
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic bus(input logic c, input logic w, input logic o);
    bus_ce_n = c; bus_we_n = w; bus_oe_n = o;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    vcc_ok = 1'b0; vcc_above_sw = 1'b0; batt_low = 1'b0;
    bus(1'b1, 1'b1, 1'b1);
    tick(3);
    chk("R1", "mem_ce_n", mem_ce_n, 1'b1);
    chk("R1", "mem_we_n", mem_we_n, 1'b1);
    chk("R1", "mem_drv_en", mem_drv_en, 1'b0);
    chk("R1", "pwr_sel_batt", pwr_sel_batt, 1'b1);
    chk("R1", "batt_bad", batt_bad, 1'b0);
    rst = 1'b0;
    tick(1);
    chk("R1", "mem_ce_n after release", mem_ce_n, 1'b1);

    // R3: switch to main supply
    vcc_above_sw = 1'b1;
    tick(SYNC);
    chk("R3", "sel before latency", pwr_sel_batt, 1'b1);
    tick(1);
    chk("R3", "sel main", pwr_sel_batt, 1'b0);
    chk("R6", "no flag with good battery", batt_bad, 1'b0);

    // R4: recovery window with a write held on the bus
    bus(1'b0, 1'b0, 1'b1);
    vcc_ok = 1'b1;
    tick(LAT - 1);
    chk("R4", "we blocked inside window", mem_we_n, 1'b1);
    chk("R4", "ce blocked inside window", mem_ce_n, 1'b1);
    tick(1);
    chk("R4", "we passes after window", mem_we_n, 1'b0);

    // R10: table of bus patterns in operation
    for (int i = 0; i < 8; i++) begin
      bus(VEC[i][5], VEC[i][4], VEC[i][3]);
      tick(1);
      chk("R10", $sformatf("ce_n vec %0d", i), mem_ce_n, VEC[i][2]);
      chk("R10", $sformatf("we_n vec %0d", i), mem_we_n, VEC[i][1]);
      chk("R10", $sformatf("drv vec %0d", i), mem_drv_en, VEC[i][0]);
    end

    // R7: weak battery while powered is not sampled
    batt_low = 1'b1;
    tick(4);
    chk("R7", "flag stays clear", batt_bad, 1'b0);
    batt_low = 1'b0;

    // R2: supply drop cuts an active write
    bus(1'b0, 1'b0, 1'b1);
    tick(1);
    chk("R2", "write active before drop", mem_we_n, 1'b0);
    vcc_ok = 1'b0;
    tick(SYNC);
    chk("R2", "write still before latency", mem_we_n, 1'b0);
    tick(1);
    chk("R2", "write cut", mem_we_n, 1'b1);
    chk("R2", "deselected", mem_ce_n, 1'b1);
    bus(1'b0, 1'b1, 1'b0);
    tick(2);
    chk("R2", "read ignored drv", mem_drv_en, 1'b0);
    chk("R2", "read ignored ce", mem_ce_n, 1'b1);

    // R5: glitch inside recovery restarts it
    vcc_ok = 1'b1;
    tick(4);
    vcc_ok = 1'b0;
    tick(1);
    vcc_ok = 1'b1;
    bus(1'b0, 1'b0, 1'b1);
    tick(LAT - 1);
    chk("R5", "still protected after restart", mem_we_n, 1'b1);
    tick(1);
    chk("R5", "released after full window", mem_we_n, 1'b0);

    // R6, R8, R9: power cycle with a weak battery
    bus(1'b1, 1'b1, 1'b1);
    vcc_ok = 1'b0;
    vcc_above_sw = 1'b0;
    tick(SYNC + 2);
    chk("R3", "sel battery", pwr_sel_batt, 1'b1);
    batt_low = 1'b1;
    vcc_above_sw = 1'b1;
    tick(SYNC);
    chk("R6", "flag before latency", batt_bad, 1'b0);
    tick(1);
    chk("R6", "flag set", batt_bad, 1'b1);
    batt_low = 1'b0;
    vcc_ok = 1'b1;
    tick(LAT + 2);
    chk("R6", "flag held after recovery", batt_bad, 1'b1);
    bus(1'b0, 1'b0, 1'b1);
    tick(1);
    chk("R8", "first write blocked", mem_we_n, 1'b1);
    chk("R8", "ce follows bus", mem_ce_n, 1'b0);
    tick(2);
    chk("R8", "blocked for whole cycle", mem_we_n, 1'b1);
    chk("R8", "flag held during cycle", batt_bad, 1'b1);
    bus(1'b0, 1'b1, 1'b1);
    tick(1);
    chk("R8", "flag cleared after cycle", batt_bad, 1'b0);
    bus(1'b0, 1'b0, 1'b1);
    tick(1);
    chk("R9", "next write passes", mem_we_n, 1'b0);
    bus(1'b1, 1'b1, 1'b1);
    tick(1);
    chk("R9", "write ends", mem_we_n, 1'b1);

    finish_run();
  end
endmodule